// File: doc/BRIEF.md
# Multicycle Variable Right-Shift Executor

This block carries out one register instruction: shift a general register right by a count taken from the instruction word. It does not use a barrel shifter. The count is loaded into a hidden temporary register. A small controller then runs a loop. Each loop cycle shifts the register right by one bit and decrements the count, until the count reaches zero.

The block contains a register file of 32 general registers plus the hidden temporary register. The file has two read ports and a write port. The datapath holds the one-bit shifter, the decrementer and the zero detector. A separate controller drives the datapath through a small set of strobes.

A start pulse launches the instruction, and a one-cycle done marks the return to fetch. Outside an instruction, a host port can write and read the general registers. This lets the surrounding logic preset operands and collect results.

Top module: `rshift_exec`

## Requirements
- R1: After reset, busy and done are low and every general register reads 0 on the read port.
- R2: While busy is low, a host write stores hostData into general register hostAddr at the clock edge. While busy is high, host writes are ignored. While busy is low, rdData shows general register rdAddr without a clock delay.
- R3: A start sampled while idle captures the instruction. DR is taken from bits [14:10] and SB from bits [4:0]. The count is the SB field zero-filled to the data width. The count is placed in the hidden temporary register, which no host address can reach. Busy rises at the same edge.
- R4: A zero count gives one done cycle right after the count is loaded, and no register changes.
- R5: Each loop cycle writes R[DR] with R[SB] shifted right by one bit. The shift is logical: a 0 enters bit 31. With DR equal to SB, a count of n leaves the register shifted right by n.
- R6: done is high for exactly one cycle. It appears n+1 cycles after the count-load edge. busy stays high from the edge that accepts start through the done cycle, then falls.
- R7: A start pulse while busy is high is ignored. The running instruction completes as if the pulse never came.
- R8: With DR different from SB, R[DR] ends as R[SB] shifted right by one, and R[SB] is left unchanged.
- R9: The SA field (bits [9:5]) and the opcode bits above bit 14 have no effect on the result or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, sampled while idle |
| instrWord | input | 32 | Instruction word: opcode, DR, SA, SB |
| hostWe | input | 1 | Host write enable for general registers |
| hostAddr | input | 5 | Host write register number |
| hostData | input | 32 | Host write data |
| rdAddr | input | 5 | Host read register number |
| rdData | output | 32 | Read data for rdAddr while idle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle return-to-fetch marker |

## Verification
The bench builds the block with its default parameters: 32-bit data and 5-bit register numbers. Register 31 and the largest count, 31, are reachable this way. A full-width shift of an all-ones word therefore leaves a single 1. That run gives the longest loop the block can perform. The default width also lets the bench drive nonzero opcode bits above bit 14 and check that the result and timing do not change.

// File: rtl/rshift_pkg.sv
package rshift_pkg;
  typedef struct packed {
    logic idle;
    logic capture;
    logic loadCount;
    logic shiftStep;
  } ctlStrb_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_FIN} ctlState_t;
endpackage

// File: rtl/rshift_regfile.sv
module rshift_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW:0]   rdAddrA,
  input  logic [REG_AW:0]   rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              we,
  input  logic [REG_AW:0]   wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tmpWe,
  input  logic [DATA_W-1:0] tmpData
);
  localparam int NGEN = 1 << REG_AW;
  localparam int NTOT = NGEN + 1;

  logic [DATA_W-1:0] mem [NTOT];

  // top address bit selects the temporary entry regardless of low bits
  function automatic logic [REG_AW:0] toIdx(input logic [REG_AW:0] a);
    return a[REG_AW] ? (REG_AW+1)'(NGEN) : {1'b0, a[REG_AW-1:0]};
  endfunction

  for (genvar g = 0; g < NTOT; g++) begin : gEntry
    if (g == NGEN) begin : gTmp
      always_ff @(posedge clk) begin
        if (!rstN) mem[g] <= '0;
        else if (we && toIdx(wrAddr) == (REG_AW+1)'(g)) mem[g] <= wrData;
        else if (tmpWe) mem[g] <= tmpData;
      end
    end else begin : gGen
      always_ff @(posedge clk) begin
        if (!rstN) mem[g] <= '0;
        else if (we && toIdx(wrAddr) == (REG_AW+1)'(g)) mem[g] <= wrData;
      end
    end
  end

  assign rdDataA = mem[toIdx(rdAddrA)];
  assign rdDataB = mem[toIdx(rdAddrB)];
endmodule

// File: rtl/rshift_dp.sv
module rshift_dp
  import rshift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 5,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrb_t           strb,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               hostWe,
  input  logic [REG_AW-1:0]  hostAddr,
  input  logic [DATA_W-1:0]  hostData,
  input  logic [REG_AW-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               fieldZero,
  output logic               decZero
);
  localparam int SB_LSB = 0;
  localparam int SA_LSB = REG_AW;
  localparam int DR_LSB = 2 * REG_AW;
  localparam int FIELD_END = DR_LSB + REG_AW;
  localparam logic [REG_AW:0] TMP_ADDR = {1'b1, {REG_AW{1'b0}}};

  logic [REG_AW-1:0] drReg, sbReg;
  logic [DATA_W-1:0] tmpVal, srcVal, decVal, shiftVal, countVal;
  logic [REG_AW:0]   portBAddr, wrAddr;
  logic [DATA_W-1:0] wrData;
  logic              we;
  logic              unusedIgnored;

  assign unusedIgnored = ^{instrWord[INSTR_W-1:FIELD_END], instrWord[DR_LSB-1:SA_LSB]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      drReg <= '0;
      sbReg <= '0;
    end else if (strb.capture) begin
      drReg <= instrWord[DR_LSB +: REG_AW];
      sbReg <= instrWord[SB_LSB +: REG_AW];
    end
  end

  assign countVal  = {{(DATA_W-REG_AW){1'b0}}, sbReg};
  assign fieldZero = (sbReg == '0);
  assign decVal    = tmpVal - 1'b1;
  assign decZero   = (decVal == '0);
  assign shiftVal  = {1'b0, srcVal[DATA_W-1:1]};

  assign portBAddr = strb.idle ? {1'b0, rdAddr} : {1'b0, sbReg};
  assign we        = strb.loadCount | strb.shiftStep | (strb.idle & hostWe);

  always_comb begin
    if (strb.loadCount) begin
      wrAddr = TMP_ADDR;
      wrData = countVal;
    end else if (strb.shiftStep) begin
      wrAddr = {1'b0, drReg};
      wrData = shiftVal;
    end else begin
      wrAddr = {1'b0, hostAddr};
      wrData = hostData;
    end
  end

  rshift_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) rfI (
    .clk(clk), .rstN(rstN),
    .rdAddrA(TMP_ADDR), .rdAddrB(portBAddr),
    .rdDataA(tmpVal), .rdDataB(srcVal),
    .we(we), .wrAddr(wrAddr), .wrData(wrData),
    .tmpWe(strb.shiftStep), .tmpData(decVal)
  );

  assign rdData = srcVal;
endmodule

// File: rtl/rshift_ctl.sv
module rshift_ctl
  import rshift_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     fieldZero,
  input  logic     decZero,
  output ctlStrb_t strb,
  output logic     busy,
  output logic     done
);
  ctlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (start) stateNext = ST_LOAD;
      ST_LOAD:  stateNext = fieldZero ? ST_FIN : ST_SHIFT;
      ST_SHIFT: if (decZero) stateNext = ST_FIN;
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strb.idle      = (state == ST_IDLE);
  assign strb.capture   = (state == ST_IDLE) && start;
  assign strb.loadCount = (state == ST_LOAD);
  assign strb.shiftStep = (state == ST_SHIFT);
  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/rshift_exec.sv
module rshift_exec
  import rshift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 5,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               hostWe,
  input  logic [REG_AW-1:0]  hostAddr,
  input  logic [DATA_W-1:0]  hostData,
  input  logic [REG_AW-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               busy,
  output logic               done
);
  ctlStrb_t ctlStrb;
  logic     fieldZero, decZero;

  rshift_ctl ctlI (
    .clk(clk), .rstN(rstN), .start(start),
    .fieldZero(fieldZero), .decZero(decZero),
    .strb(ctlStrb), .busy(busy), .done(done)
  );

  rshift_dp #(.DATA_W(DATA_W), .REG_AW(REG_AW), .INSTR_W(INSTR_W)) dpI (
    .clk(clk), .rstN(rstN), .strb(ctlStrb), .instrWord(instrWord),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData),
    .rdAddr(rdAddr), .rdData(rdData),
    .fieldZero(fieldZero), .decZero(decZero)
  );
endmodule

// File: rtl/rshift_exec_chk.sv
module rshift_exec_chk
  import rshift_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     start,
  input logic     busy,
  input logic     done,
  input ctlStrb_t strb
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r6_done_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  a_r3_start_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done));
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> !busy);
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capture, strb.loadCount, strb.shiftStep}));
endmodule

bind rshift_exec rshift_exec_chk chkI (
  .clk(clk), .rstN(rstN), .start(start),
  .busy(busy), .done(done), .strb(ctlStrb)
);

// File: tb/rshift_exec_tb_top.sv
`timescale 1ns/100ps
module rshift_exec_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instrWord = '0;
  logic        hostWe = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [31:0] hostData = '0;
  logic [4:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        busy, done;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rshift_exec dut_i (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrWord),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 count pending, 2 looping, 3 returning
  logic [31:0] mRegs [32];
  int mPhase, mCnt, mDr, mSb;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0;
      mCnt = 0;
      for (int i = 0; i < 32; i++) mRegs[i] = '0;
    end else begin
      case (mPhase)
        0: begin
          if (hostWe) mRegs[hostAddr] = hostData;
          if (start) begin
            mDr = int'(instrWord[14:10]);
            mSb = int'(instrWord[4:0]);
            mPhase = 1;
          end
        end
        1: begin
          mCnt = mSb;
          mPhase = (mCnt == 0) ? 3 : 2;
        end
        2: begin
          mRegs[mDr] = mRegs[mSb] >> 1;
          mCnt--;
          if (mCnt == 0) mPhase = 3;
        end
        default: mPhase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(busy === (mPhase != 0), "R6 busy per-cycle", 32'(busy), 32'(mPhase != 0));
      check(done === (mPhase == 3), "R6 done per-cycle", 32'(done), 32'(mPhase == 3));
      if (mPhase == 0)
        check(rdData === mRegs[rdAddr], "R5 read port per-cycle", rdData, mRegs[rdAddr]);
    end
  end

  task automatic hostWrite(input logic [4:0] a, input logic [31:0] d);
    hostWe = 1'b1; hostAddr = a; hostData = d;
    @(posedge clk); #1;
    hostWe = 1'b0;
  endtask

  task automatic checkReg(input logic [4:0] a, input logic [31:0] exp, input string tag);
    rdAddr = a;
    @(negedge clk);
    check(rdData === exp, tag, rdData, exp);
  endtask

  // disturbAt >= 0 drives a start pulse and a host write in that loop cycle
  task automatic runInstr(input logic [4:0] dr, input logic [4:0] sa, input logic [4:0] sb,
                          input logic [16:0] opc, input int disturbAt, input string tag);
    int j;
    instrWord = {opc, dr, sa, sb};
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    j = 0;
    forever begin
      @(negedge clk);
      if (j == disturbAt) begin
        start = 1'b1; instrWord = 32'hFFFF_FFFF;
        hostWe = 1'b1; hostAddr = 5'd5; hostData = 32'h1111_1111;
      end else if (j == disturbAt + 1) begin
        start = 1'b0; hostWe = 1'b0;
      end
      if (done || j > 100) break;
      j++;
    end
    check(j == int'(sb) + 1, tag, 32'(j), 32'(int'(sb) + 1));
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1 busy after reset", 32'(busy), 32'd0);
    check(done === 1'b0, "R1 done after reset", 32'(done), 32'd0);
    checkReg(5'd5, 32'h0, "R1 reg5 after reset");
    checkReg(5'd31, 32'h0, "R1 reg31 after reset");
    @(posedge clk); #1;

    hostWrite(5'd7,  32'h8000_0001);
    hostWrite(5'd31, 32'hFFFF_FFFF);
    hostWrite(5'd0,  32'hDEAD_BEEF);
    hostWrite(5'd3,  32'hF000_000F);
    hostWrite(5'd9,  32'h1234_5678);
    hostWrite(5'd12, 32'hA5A5_A5A5);
    hostWrite(5'd20, 32'hFFFF_0000);
    checkReg(5'd7, 32'h8000_0001, "R2 idle host write");
    @(posedge clk); #1;

    runInstr(5'd0, 5'd0, 5'd0, 17'd0, -5, "R4 zero count latency");
    checkReg(5'd0, 32'hDEAD_BEEF, "R4 zero count leaves reg");
    @(posedge clk); #1;

    runInstr(5'd7, 5'd0, 5'd7, 17'd0, -5, "R3 R6 latency count 7");
    checkReg(5'd7, 32'h0100_0000, "R5 shift by 7");
    @(posedge clk); #1;

    runInstr(5'd31, 5'd0, 5'd31, 17'd0, -5, "R6 latency count 31");
    checkReg(5'd31, 32'h0000_0001, "R5 logical shift by 31");
    @(posedge clk); #1;

    runInstr(5'd3, 5'd0, 5'd3, 17'd0, -5, "R6 latency count 3");
    checkReg(5'd3, 32'h1E00_0001, "R5 shift by 3");
    @(posedge clk); #1;

    runInstr(5'd12, 5'd4, 5'd9, 17'd0, -5, "R8 latency count 9");
    checkReg(5'd12, 32'h091A_2B3C, "R8 dest gets source shifted once");
    checkReg(5'd9, 32'h1234_5678, "R8 source unchanged");
    @(posedge clk); #1;

    runInstr(5'd3, 5'd21, 5'd3, 17'h1ABCD, -5, "R9 latency with SA and opcode set");
    checkReg(5'd3, 32'h03C0_0000, "R9 result with SA and opcode set");
    @(posedge clk); #1;

    runInstr(5'd20, 5'd0, 5'd20, 17'd0, 5, "R7 latency with start while busy");
    checkReg(5'd20, 32'h0000_0FFF, "R7 shift by 20 with disturbance");
    checkReg(5'd5, 32'h0000_0000, "R2 host write ignored while busy");
    @(posedge clk); #1;

    hostWrite(5'd5, 32'h0BAD_F00D);
    checkReg(5'd5, 32'h0BAD_F00D, "R2 host write after return");
    @(posedge clk); #1;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule